// File: doc/BRIEF.md
# Receive FIFO Flow-Control Hysteresis Unit

This block watches the fill count of a UART receive FIFO and decides when the local receiver should ask the far-end transmitter to pause, and when it should let it continue. The decision uses two programmable thresholds, a pause level and a resume level. Both sit in one 8-bit configuration register, and each is coded as a 4-bit value in units of four entries. The gap between the two levels gives hysteresis, so the link does not toggle on every byte.

The register can be written only while two separate unlock qualifiers are both high. Writes at other times are ignored. The register value is always visible on a read-back port.

The pause decision drives one of two outputs, chosen by a mode pin. In pin mode it drives a request-to-send style level. In character mode it raises one-cycle requests that tell an external character generator to send a stop or a resume character. The thresholds should be loaded before flow control is enabled. The block does not check that the pause level is above the resume level, but it behaves deterministically when the two are inverted. All pins are plain level signals; there is no streamed data path and no handshake.

Top module: `rx_flow_hyst`

## Requirements
- R1: After reset the configuration read-back is 8'h00, `halt` is 0, `rts_n` is 0, and both character requests are 0.
- R2: A write (`cfg_wr_en`=1) with `unlock_feat`=1 and `unlock_mode`=1 loads `cfg_wr_data` at the clock edge, and `cfg_rd_data` shows it in the following cycle. Bits 3:0 hold the pause nibble and bits 7:4 hold the resume nibble.
- R3: A write while either unlock input is 0 leaves the register unchanged.
- R4: The pause threshold is 4 times the pause nibble. If `flow_en`=1, `halt` is 0 and `rx_count` is at or above the pause threshold at a clock edge, `halt` is 1 after that edge.
- R5: Once set, `halt` stays 1 until an edge at which `rx_count` is at or below 4 times the resume nibble and also below the pause threshold. After that edge `halt` is 0.
- R6: While `flow_en`=0, `halt` is cleared at the next edge and stays 0 whatever `rx_count` is.
- R7: With `flow_mode`=0 (pin mode), `rts_n` equals `halt`, so 1 means pause. With `flow_mode`=1, `rts_n` is 0.
- R8: With `flow_mode`=1 and `flow_en`=1, `xoff_req` is high for exactly one cycle, in the cycle right after `halt` rises. `xon_req` is high for exactly one cycle, in the cycle right after `halt` falls. Neither is ever high in pin mode or while `flow_en`=0, and the two are never high together.
- R9: With inverted thresholds (pause level at or below the resume level), `halt` stays 1 for as long as `rx_count` is at or above the pause level. A pause nibble of 0 keeps `halt` at 1 whenever flow control is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 8 | Write data: [7:4] resume nibble, [3:0] pause nibble |
| unlock_feat | input | 1 | First write qualifier |
| unlock_mode | input | 1 | Second write qualifier |
| flow_en | input | 1 | Enables flow control |
| flow_mode | input | 1 | 0 = pin mode, 1 = character mode |
| rx_count | input | 7 | Current receive FIFO fill count |
| cfg_rd_data | output | 8 | Current register contents |
| halt | output | 1 | Pause decision (1 = remote should pause) |
| rts_n | output | 1 | Request-to-send level, 1 = pause (pin mode) |
| xoff_req | output | 1 | One-cycle request to send a stop character |
| xon_req | output | 1 | One-cycle request to send a resume character |

## Verification
The in-line assertions check on every cycle that gated-off writes leave the register untouched and that the pause state sets and holds against the thresholds. They also check that disabling clears it and that each character request is a single, exclusive pulse. Only the bench scenarios can show the nibble-to-threshold scaling at exact boundary counts and the pin-mode versus character-mode output choice. They also cover the deterministic behaviour under inverted thresholds and the absence of a resume request when flow control is switched off while paused.

// File: rtl/rfh_pkg.sv
package rfh_pkg;
  localparam int NIB_W      = 4;
  localparam int STEP_SHIFT = 2;
  localparam int CFG_W      = 2 * NIB_W;

  // Field order is significant: resume nibble in the upper half.
  typedef struct packed {
    logic [NIB_W-1:0] resume_nib;
    logic [NIB_W-1:0] pause_nib;
  } rfh_cfg_t;

  typedef enum logic {
    MODE_PIN  = 1'b0,
    MODE_CHAR = 1'b1
  } rfh_mode_e;
endpackage

// File: rtl/rfh_cfg_reg.sv
module rfh_cfg_reg
  import rfh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             unlock_feat,
  input  logic             unlock_mode,
  output rfh_cfg_t         cfg_q
);
  logic wr_ok;
  assign wr_ok = wr_en & unlock_feat & unlock_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_ok) cfg_q <= rfh_cfg_t'(wr_data);
  end

  // R3: a write without both qualifiers leaves the register alone
  a_r3_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(unlock_feat && unlock_mode)) |=> $stable(cfg_q));
  // R2: an unlocked write lands in the register
  a_r2_unlocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unlock_feat && unlock_mode) |=> (cfg_q == $past(wr_data)));
endmodule

// File: rtl/rfh_hyst.sv
module rfh_hyst
  import rfh_pkg::*;
#(
  parameter int COUNT_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flow_en,
  input  rfh_cfg_t           cfg,
  input  logic [COUNT_W-1:0] rx_count,
  output logic               halt_q
);
  localparam int THR_W = NIB_W + STEP_SHIFT;
  localparam int CMP_W = COUNT_W + THR_W;

  logic [CMP_W-1:0] pause_thr, resume_thr, cnt_ext;
  logic             set_cond, clr_cond, halt_d;

  assign pause_thr  = CMP_W'(cfg.pause_nib)  << STEP_SHIFT;
  assign resume_thr = CMP_W'(cfg.resume_nib) << STEP_SHIFT;
  assign cnt_ext    = CMP_W'(rx_count);

  assign set_cond = cnt_ext >= pause_thr;
  // Release also needs the count below the pause level, so inverted
  // thresholds settle in the paused state.
  assign clr_cond = (cnt_ext <= resume_thr) && !set_cond;

  always_comb begin
    halt_d = halt_q;
    if (!flow_en)               halt_d = 1'b0;
    else if (!halt_q && set_cond) halt_d = 1'b1;
    else if (halt_q && clr_cond)  halt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_d;
  end

  // R4: reaching the pause threshold sets halt
  a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && (cnt_ext >= pause_thr)) |=> halt_q);
  // R5: halt holds while the count stays above the resume level
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && halt_q && (cnt_ext > resume_thr)) |=> halt_q);
  // R6: disabling clears halt
  a_r6_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en |=> !halt_q);
endmodule

// File: rtl/rfh_signal.sv
module rfh_signal
  import rfh_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      halt,
  input  logic      flow_en,
  input  rfh_mode_e mode,
  output logic      rts_n,
  output logic      xoff_req,
  output logic      xon_req
);
  logic halt_prev;
  logic chr_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_prev <= 1'b0;
    else        halt_prev <= halt;
  end

  assign chr_active = flow_en && (mode == MODE_CHAR);
  assign rts_n      = (mode == MODE_PIN) ? halt : 1'b0;
  assign xoff_req   = chr_active &&  halt && !halt_prev;
  assign xon_req    = chr_active && !halt &&  halt_prev;

  // R8: requests are exclusive single-cycle pulses
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xoff_req, xon_req}));
  a_r8_xoff_single: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_req |=> !xoff_req);
  a_r8_xon_single: assert property (@(posedge clk) disable iff (!rst_n)
    xon_req |=> !xon_req);
  a_r8_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PIN) |-> !(xoff_req || xon_req));
endmodule

// File: rtl/rx_flow_hyst.sv
module rx_flow_hyst
  import rfh_pkg::*;
#(
  parameter int COUNT_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [7:0]         cfg_wr_data,
  input  logic               unlock_feat,
  input  logic               unlock_mode,
  input  logic               flow_en,
  input  logic               flow_mode,
  input  logic [COUNT_W-1:0] rx_count,
  output logic [7:0]         cfg_rd_data,
  output logic               halt,
  output logic               rts_n,
  output logic               xoff_req,
  output logic               xon_req
);
  rfh_cfg_t cfg_q;

  rfh_cfg_reg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cfg_wr_en),
    .wr_data     (cfg_wr_data),
    .unlock_feat (unlock_feat),
    .unlock_mode (unlock_mode),
    .cfg_q       (cfg_q)
  );

  rfh_hyst #(.COUNT_W(COUNT_W)) u_hyst (
    .clk      (clk),
    .rst_n    (rst_n),
    .flow_en  (flow_en),
    .cfg      (cfg_q),
    .rx_count (rx_count),
    .halt_q   (halt)
  );

  rfh_signal u_sig (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (halt),
    .flow_en  (flow_en),
    .mode     (rfh_mode_e'(flow_mode)),
    .rts_n    (rts_n),
    .xoff_req (xoff_req),
    .xon_req  (xon_req)
  );

  assign cfg_rd_data = cfg_q;
endmodule

// File: tb/rx_flow_hyst_bench.sv
module rx_flow_hyst_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic       unlock_feat = 1'b0, unlock_mode = 1'b0;
  logic       flow_en = 1'b0, flow_mode = 1'b0;
  logic [6:0] rx_count = '0;
  logic [7:0] cfg_rd_data;
  logic       halt, rts_n, xoff_req, xon_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_flow_hyst u_rx_flow_hyst (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .unlock_feat(unlock_feat), .unlock_mode(unlock_mode), .flow_en(flow_en),
    .flow_mode(flow_mode), .rx_count(rx_count), .cfg_rd_data(cfg_rd_data),
    .halt(halt), .rts_n(rts_n), .xoff_req(xoff_req), .xon_req(xon_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at falling edge, then sample just after the next rising edge
  task automatic step(input logic [6:0] cnt);
    @(negedge clk);
    rx_count = cnt;
    @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic [7:0] d, input logic ua, input logic ub);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = d; unlock_feat = ua; unlock_mode = ub;
    @(negedge clk);
    cfg_wr_en = 1'b0; unlock_feat = 1'b0; unlock_mode = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 cfg", cfg_rd_data, 0);
    chk("R1 halt", halt, 0);
    chk("R1 rts_n", rts_n, 0);
    chk("R1 req", {xoff_req, xon_req}, 0);
  endtask

  task automatic t_write_lock;
    write_cfg(8'h13, 1'b1, 1'b1);
    chk("R2 write", cfg_rd_data, 8'h13);
    write_cfg(8'hA5, 1'b1, 1'b0);
    chk("R3 only feat", cfg_rd_data, 8'h13);
    write_cfg(8'hA5, 1'b0, 1'b1);
    chk("R3 only mode", cfg_rd_data, 8'h13);
    write_cfg(8'hA5, 1'b0, 1'b0);
    chk("R3 none", cfg_rd_data, 8'h13);
  endtask

  // pause nibble 3 -> 12, resume nibble 1 -> 4
  task automatic t_pin_mode;
    write_cfg(8'h13, 1'b1, 1'b1);
    flow_mode = 1'b0; flow_en = 1'b1;
    step(7'd11); chk("R4 below", halt, 0);
    step(7'd12); chk("R4 at thr", halt, 1);
    chk("R7 pin rts", rts_n, 1);
    chk("R8 pin quiet", xoff_req, 0);
    step(7'd5);  chk("R5 hold", halt, 1);
    step(7'd4);  chk("R5 release", halt, 0);
    chk("R7 pin rts low", rts_n, 0);
    chk("R8 pin quiet xon", xon_req, 0);
  endtask

  task automatic t_char_mode;
    flow_mode = 1'b1;
    step(7'd20); chk("R8 xoff pulse", xoff_req, 1);
    chk("R7 char rts", rts_n, 0);
    step(7'd20); chk("R8 xoff single", xoff_req, 0);
    step(7'd3);  chk("R8 xon pulse", xon_req, 1);
    chk("R8 no xoff", xoff_req, 0);
    step(7'd3);  chk("R8 xon single", xon_req, 0);
  endtask

  task automatic t_disable;
    step(7'd40); chk("R4 char halt", halt, 1);
    @(negedge clk); flow_en = 1'b0;
    @(posedge clk); #1;
    chk("R6 cleared", halt, 0);
    chk("R8 no xon on disable", xon_req, 0);
    step(7'd100); chk("R6 stays clear", halt, 0);
    chk("R8 disabled quiet", {xoff_req, xon_req}, 0);
    flow_en = 1'b1;
  endtask

  // pause nibble 2 -> 8, resume nibble 10 -> 40
  task automatic t_inverted;
    flow_mode = 1'b0;
    step(7'd0);
    write_cfg(8'hA2, 1'b1, 1'b1);
    step(7'd20); chk("R9 set", halt, 1);
    step(7'd20); chk("R9 hold", halt, 1);
    step(7'd20); chk("R9 hold2", halt, 1);
    step(7'd7);  chk("R9 release", halt, 0);
    write_cfg(8'h00, 1'b1, 1'b1);
    step(7'd0);  chk("R9 zero thr", halt, 1);
    step(7'd0);  chk("R9 zero hold", halt, 1);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD*3); rst_n = 1'b1;
        t_reset();
        t_write_lock();
        t_pin_mode();
        t_char_mode();
        t_disable();
        t_inverted();
      end
      begin
        #(CLK_PERIOD*20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule